// File: doc/BRIEF.md
# Processor exception entry unit

This block holds the exception-side control state of a simple in-order 32-bit RISC core and performs the whole entry sequence in one clock edge. When the pipeline raises a fault it presents a 5-bit exception code, a vector-class flag, the PC of the faulting instruction and the next PC. On the following edge the unit marks the core as being at exception level. It saves a restart PC that accounts for branch delay slots and records the cause. It conditionally switches the shadow register set. It emits a one-cycle redirect pulse carrying the handler address for fetch.

A separate reset request redirects fetch to the fixed reset address and enables coprocessor 1. A small control-write port lets the surrounding core load the exception-level bit, the boot-vector bit and the current shadow set. This port is how handlers leave exception level or move the vectors. It is accepted only in a cycle with no request.

Top module: `exc_entry_unit`

## Requirements
- R1: After `rst_n` is low, `stat_exl`=0, `stat_bev`=1, `stat_cu1`=0, `srs_cur`=0, `srs_prev`=0, `epc`=0, `cause`=0 and `redir_valid`=0.
- R2: An accepted fault sets `stat_exl` to 1, even when it was already 1.
- R3: On an accepted fault with `stat_exl`=0 and `stat_bev`=0, `srs_prev` takes the old `srs_cur` and `srs_cur` takes `ess_cfg`. Otherwise both are left unchanged.
- R4: If `next_pc` differs from `cur_pc`+4, the fault is in a delay slot. `epc` then gets `cur_pc`-4 and `cause` bit 31 is set. Otherwise `epc` gets `cur_pc` and bit 31 is cleared.
- R5: On an accepted fault, `cause` bits 6:2 take `fault_code` and bits 29:28 are cleared. All other `cause` bits read 0.
- R6: The fault handler address is a base plus an offset. The base is 0xBFC00200 when `stat_bev`=1 and 0x80000000 when it is 0. The offset is 0x180, or 0x000 when `fault_vec0`=1.
- R7: A reset request redirects to 0xBFC00000 and sets `stat_cu1`. It changes no other register.
- R8: When `reset_req` and `fault_req` are both high, only the reset request is taken.
- R9: `redir_valid` is high for exactly the cycle after an accepted request, together with the updated registers. It is low after a cycle with no request.
- R10: `ctl_wr` loads `stat_exl`, `stat_bev` and `srs_cur` from `ctl_exl`, `ctl_bev` and `ctl_css`. It has no effect in a cycle with a fault or reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_req | input | 1 | Fault request |
| fault_code | input | 5 | Exception code of the fault |
| fault_vec0 | input | 1 | 1 selects vector offset 0x000 (interrupt class) |
| reset_req | input | 1 | Reset request |
| cur_pc | input | 32 | PC of the faulting instruction |
| next_pc | input | 32 | Next PC at the time of the fault |
| ess_cfg | input | 4 | Shadow set to use for exceptions |
| ctl_wr | input | 1 | Control-write strobe |
| ctl_exl | input | 1 | Value written to the exception-level bit |
| ctl_bev | input | 1 | Value written to the boot-vector bit |
| ctl_css | input | 4 | Value written to the current shadow set |
| redir_valid | output | 1 | One-cycle fetch redirect pulse |
| redir_pc | output | 32 | Handler address |
| stat_exl | output | 1 | Exception-level bit |
| stat_bev | output | 1 | Boot-vector bit |
| stat_cu1 | output | 1 | Coprocessor 1 usable bit |
| srs_cur | output | 4 | Current shadow set |
| srs_prev | output | 4 | Previous shadow set |
| epc | output | 32 | Saved restart PC |
| cause | output | 32 | Cause register (BD 31, CE 29:28, code 6:2) |

## Verification
The bench aims at the shadow-set switch when exactly one of the exception-level and boot-vector bits is set. A design that tested only one of them would rotate the sets while already inside a handler. Faults are driven with `next_pc` both equal to and different from `cur_pc`+4. A design with the slot test inverted or the wrong adjustment would save a restart PC one instruction off and misreport bit 31. Simultaneous reset and fault requests, and control writes colliding with requests, are forced. These expose a wrong priority, which would show as a general-vector redirect or a lost exception-level bit. The vector base is checked under both boot-vector settings.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int unsigned XLEN    = 32;
    localparam int unsigned SET_W   = 4;
    localparam int unsigned CODE_W  = 5;
    localparam int unsigned CE_W    = 2;

    typedef struct packed {
        logic              exl;
        logic              bev;
        logic              cu1;
        logic [SET_W-1:0]  css;
        logic [SET_W-1:0]  pss;
        logic [XLEN-1:0]   epc;
        logic              bd;
        logic [CE_W-1:0]   ce;
        logic [CODE_W-1:0] code;
        logic              rv;
        logic [XLEN-1:0]   rpc;
    } exc_state_t;
endpackage

// File: rtl/exc_slot_detect.sv
module exc_slot_detect #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] npc_in,
    output logic            in_slot,
    output logic [XLEN-1:0] restart_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_comb begin
        in_slot    = (npc_in != (pc_in + STEP));
        restart_pc = in_slot ? (pc_in - STEP) : pc_in;
    end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
    parameter int unsigned     XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] BOOT_BASE = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] RUN_BASE  = 32'h8000_0000,
    parameter logic [XLEN-1:0] GEN_OFS   = 32'h0000_0180
) (
    input  logic            is_reset,
    input  logic            bev,
    input  logic            vec0,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] ofs;

    always_comb begin
        base   = bev  ? BOOT_BASE : RUN_BASE;
        ofs    = vec0 ? '0 : GEN_OFS;
        target = is_reset ? RESET_VEC : (base + ofs);
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC  = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] BOOT_BASE  = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] RUN_BASE   = 32'h8000_0000,
    parameter logic [XLEN-1:0] GEN_OFS    = 32'h0000_0180,
    parameter int unsigned     INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_req,
    input  logic [CODE_W-1:0] fault_code,
    input  logic              fault_vec0,
    input  logic              reset_req,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [SET_W-1:0]  ess_cfg,
    input  logic              ctl_wr,
    input  logic              ctl_exl,
    input  logic              ctl_bev,
    input  logic [SET_W-1:0]  ctl_css,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_pc,
    output logic              stat_exl,
    output logic              stat_bev,
    output logic              stat_cu1,
    output logic [SET_W-1:0]  srs_cur,
    output logic [SET_W-1:0]  srs_prev,
    output logic [XLEN-1:0]   epc,
    output logic [XLEN-1:0]   cause
);
    localparam int unsigned BD_POS   = XLEN - 1;
    localparam int unsigned CE_LO    = XLEN - 4;
    localparam int unsigned CODE_LO  = 2;

    exc_state_t st_d, st_q;
    logic            slot_d;
    logic [XLEN-1:0] rest_pc_d;
    logic [XLEN-1:0] target_d;

    exc_slot_detect #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) i_slot (
        .pc_in      (cur_pc),
        .npc_in     (next_pc),
        .in_slot    (slot_d),
        .restart_pc (rest_pc_d)
    );

    exc_vector_sel #(
        .XLEN(XLEN), .RESET_VEC(RESET_VEC), .BOOT_BASE(BOOT_BASE),
        .RUN_BASE(RUN_BASE), .GEN_OFS(GEN_OFS)
    ) i_vec (
        .is_reset (reset_req),
        .bev      (st_q.bev),
        .vec0     (fault_vec0),
        .target   (target_d)
    );

    always_comb begin
        st_d    = st_q;
        st_d.rv = 1'b0;
        if (reset_req) begin
            st_d.cu1 = 1'b1;
            st_d.rv  = 1'b1;
            st_d.rpc = target_d;
        end else if (fault_req) begin
            st_d.exl = 1'b1;
            if (!st_q.exl && !st_q.bev) begin
                st_d.pss = st_q.css;
                st_d.css = ess_cfg;
            end
            st_d.epc  = rest_pc_d;
            st_d.bd   = slot_d;
            st_d.ce   = '0;
            st_d.code = fault_code;
            st_d.rv   = 1'b1;
            st_d.rpc  = target_d;
        end else if (ctl_wr) begin
            st_d.exl = ctl_exl;
            st_d.bev = ctl_bev;
            st_d.css = ctl_css;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.bev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        redir_valid = st_q.rv;
        redir_pc    = st_q.rpc;
        stat_exl    = st_q.exl;
        stat_bev    = st_q.bev;
        stat_cu1    = st_q.cu1;
        srs_cur     = st_q.css;
        srs_prev    = st_q.pss;
        epc         = st_q.epc;
        cause                          = '0;
        cause[BD_POS]                  = st_q.bd;
        cause[CE_LO +: CE_W]           = st_q.ce;
        cause[CODE_LO +: CODE_W]       = st_q.code;
    end

    // Fault taken always leaves the core at exception level
    assert_exl_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_req && !reset_req) |=> stat_exl);

    // Shadow sets frozen when already at exception level or on boot vectors
    assert_srs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_req && !reset_req && (stat_exl || stat_bev))
        |=> (srs_cur == $past(srs_cur) && srs_prev == $past(srs_prev)));

    // Delay-slot flag follows the next-PC relation
    assert_bd_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_req && !reset_req)
        |=> (cause[BD_POS] == $past(next_pc != cur_pc + XLEN'(INSN_BYTES))));

    // Reset request redirects to the reset address with coprocessor 1 on
    assert_reset_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (redir_valid && redir_pc == RESET_VEC && stat_cu1));

    // Reset wins: exception-level bit untouched by a simultaneous fault
    assert_reset_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && fault_req) |=> $stable(stat_exl));

    // No request, no redirect
    assert_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_req || reset_req) |=> !redir_valid);
endmodule

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fault_req, fault_vec0, reset_req, ctl_wr, ctl_exl, ctl_bev;
    logic [4:0]  fault_code;
    logic [31:0] cur_pc, next_pc;
    logic [3:0]  ess_cfg, ctl_css;
    logic        redir_valid, stat_exl, stat_bev, stat_cu1;
    logic [31:0] redir_pc, epc, cause;
    logic [3:0]  srs_cur, srs_prev;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model state
    bit          m_exl, m_bev, m_cu1, m_bd, m_rv;
    logic [3:0]  m_css, m_pss;
    logic [4:0]  m_code;
    logic [31:0] m_epc, m_rpc;

    always #10 clk = ~clk;

    exc_entry_unit i_exc_entry_unit (
        .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .fault_code(fault_code),
        .fault_vec0(fault_vec0), .reset_req(reset_req), .cur_pc(cur_pc),
        .next_pc(next_pc), .ess_cfg(ess_cfg), .ctl_wr(ctl_wr), .ctl_exl(ctl_exl),
        .ctl_bev(ctl_bev), .ctl_css(ctl_css), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .stat_exl(stat_exl), .stat_bev(stat_bev),
        .stat_cu1(stat_cu1), .srs_cur(srs_cur), .srs_prev(srs_prev),
        .epc(epc), .cause(cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] handler(input bit bev, input bit v0);
        return (bev ? 32'hBFC0_0200 : 32'h8000_0000) + (v0 ? 32'h0 : 32'h180);
    endfunction

    function automatic logic [31:0] exp_cause(input bit bd, input logic [4:0] c);
        return {bd, 24'h0, c, 2'b00};
    endfunction

    task automatic idle_inputs();
        fault_req = 0; fault_vec0 = 0; reset_req = 0; ctl_wr = 0;
        ctl_exl = 0; ctl_bev = 0; fault_code = 0; ctl_css = 0;
    endtask

    // apply model update for the inputs currently driven
    task automatic model_step();
        m_rv = 0;
        if (reset_req) begin
            m_cu1 = 1; m_rv = 1; m_rpc = 32'hBFC0_0000;
        end else if (fault_req) begin
            m_rpc = handler(m_bev, fault_vec0);
            if (!m_exl && !m_bev) begin m_pss = m_css; m_css = ess_cfg; end
            m_exl = 1;
            m_bd  = (next_pc != cur_pc + 32'd4);
            m_epc = m_bd ? cur_pc - 32'd4 : cur_pc;
            m_code = fault_code;
            m_rv = 1;
        end else if (ctl_wr) begin
            m_exl = ctl_exl; m_bev = ctl_bev; m_css = ctl_css;
        end
    endtask

    task automatic compare_all();
        chk("R9 redir_valid", {31'b0, redir_valid}, {31'b0, m_rv});
        if (m_rv) chk("R6/R7 redir_pc", redir_pc, m_rpc);
        chk("R2/R10 stat_exl", {31'b0, stat_exl}, {31'b0, m_exl});
        chk("R10 stat_bev", {31'b0, stat_bev}, {31'b0, m_bev});
        chk("R7 stat_cu1", {31'b0, stat_cu1}, {31'b0, m_cu1});
        chk("R3 srs_cur", {28'b0, srs_cur}, {28'b0, m_css});
        chk("R3 srs_prev", {28'b0, srs_prev}, {28'b0, m_pss});
        chk("R4 epc", epc, m_epc);
        chk("R4/R5 cause", cause, exp_cause(m_bd, m_code));
    endtask

    // inputs are driven 5 ns after a rising edge; results sampled 5 ns after the next
    task automatic step();
        model_step();
        @(posedge clk); #5;
        compare_all();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        idle_inputs();
        cur_pc = 32'h1000; next_pc = 32'h1004; ess_cfg = 4'h5;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #5; rst_n = 1;
        // R1 reset state
        m_exl = 0; m_bev = 1; m_cu1 = 0; m_css = 0; m_pss = 0;
        m_epc = 0; m_bd = 0; m_code = 0; m_rv = 0; m_rpc = 0;
        compare_all();

        // R3 fault while on boot vectors: no switch, boot base used (R6)
        fault_req = 1; fault_code = 5'd8; step();
        // R10 leave exception level, run vectors, css=3
        idle_inputs(); ctl_wr = 1; ctl_css = 4'h3; step();
        // R3 switch sets, R4 delay slot, R6 run base general offset
        idle_inputs(); fault_req = 1; fault_code = 5'd12;
        cur_pc = 32'h2000; next_pc = 32'h3000; step();
        chk("R3 prev=old cur", {28'b0, srs_prev}, 32'h3);
        chk("R4 bd epc", epc, 32'h1FFC);
        // R2 fault while exl=1: exl stays, no switch; R6 offset 0 class
        idle_inputs(); fault_req = 1; fault_vec0 = 1; fault_code = 5'd0;
        next_pc = 32'h2004; step();
        chk("R6 vec0 run base", redir_pc, 32'h8000_0000);
        // R8 both requests; R10 write during request ignored
        idle_inputs(); ctl_wr = 1; ctl_exl = 0; fault_req = 1; reset_req = 1; step();
        chk("R8 reset vector", redir_pc, 32'hBFC0_0000);
        // R10 write with exl=0 bev=1
        idle_inputs(); ctl_wr = 1; ctl_bev = 1; ctl_css = 4'h9; step();
        // R3 bev alone blocks switch
        idle_inputs(); fault_req = 1; fault_code = 5'd24; step();
        idle_inputs(); step();   // R9 pulse ends

        for (int i = 0; i < 400; i++) begin
            idle_inputs();
            reset_req  = ($urandom % 10) == 0;
            fault_req  = ($urandom % 2) == 0;
            ctl_wr     = ($urandom % 4) == 0;
            ctl_exl    = $urandom % 2;
            ctl_bev    = $urandom % 2;
            ctl_css    = 4'($urandom);
            ess_cfg    = 4'($urandom);
            fault_vec0 = ($urandom % 4) == 0;
            fault_code = 5'($urandom);
            cur_pc     = {$urandom} & 32'hFFFF_FFFC;
            next_pc    = ($urandom % 2) ? cur_pc + 32'd4 : ({$urandom} & 32'hFFFF_FFFC);
            step();
        end
        idle_inputs(); step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule